// File: doc/BRIEF.md
# Multifunction Self-Test Register

The block is a WIDTH-bit register that a two-bit mode code switches between four roles. It can capture the outputs of upstream logic in parallel. It can act as one link of a serial scan chain. It can clear itself on a clock edge. Its fourth role is self-test: each stage folds its parallel input into the value arriving from the stage before it, and stage 0 is fed back from a fixed set of tap stages. With live inputs this compacts a response stream into a signature. With the inputs held at zero it runs as a maximal-length pseudo-random pattern source.

A typical arrangement places two of these registers around a block of combinational logic. The upstream register generates stimulus patterns, and the downstream register compresses the responses into a signature that is read out through the scan chain. Every change of mode or data takes effect at the next rising clock edge. The only other control is a global synchronous reset.

Top module: `selftest_reg`

## Requirements
- R1: While rst_n is low at a rising edge, every stage becomes 0 after that edge, whatever the mode and data inputs are.
- R2: With mode_ctl = 2'b11 (capture), each stage i loads par_in[i] at the edge.
- R3: With mode_ctl = 2'b00 (scan), stage 0 loads scan_in and stage i loads the old value of stage i-1, so bits move from index 0 toward index WIDTH-1.
- R4: scan_out always equals the last stage, par_out[WIDTH-1], in every mode.
- R5: With mode_ctl = 2'b10 (self-test), stage i (i > 0) loads par_in[i] XOR old stage i-1, and stage 0 loads par_in[0] XOR the feedback bit. For WIDTH = 4 the feedback bit is stage 3 XOR stage 2, which is the polynomial x^4+x^3+1.
- R6: With mode_ctl = 2'b01 (clear), every stage becomes 0 at the edge, whatever par_in and scan_in are.
- R7: In self-test mode with par_in held at zero and a nonzero starting value, the register passes through 2^WIDTH-1 distinct nonzero states and then returns to its starting value.
- R8: In self-test mode with par_in held at zero, an all-zero register stays all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ctl | input | 2 | Mode code: 11 capture, 00 scan, 10 self-test, 01 clear |
| par_in | input | WIDTH | Parallel data from the upstream logic |
| scan_in | input | 1 | Serial input to stage 0 |
| par_out | output | WIDTH | Current value of all stages |
| scan_out | output | 1 | Serial output taken from the last stage |

## Verification
The properties assume that mode_ctl, par_in and scan_in carry known values at every rising edge where rst_n is high. They also assume that rst_n is low at the first edge, so that the register starts from a defined value. The bench holds reset low for the first cycles and changes every input only at falling edges. It fills par_in and scan_in with either pseudo-random values or deliberate corner values, such as zero inputs with a single-bit seed or an all-zero state, so that no undefined value ever reaches the register.

// File: rtl/selftest_pkg.sv
// Package: shared mode encoding, stage-control struct and feedback tap table
// for the multifunction self-test register.
// Assumes register widths from 2 to 16. Widths outside that range get an
// empty tap mask.
package selftest_pkg;

    // Two-bit mode code applied on mode_ctl.
    typedef enum logic [1:0] {
        MODE_SCAN  = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIG   = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    // Decoded one-hot stage control.
    typedef struct packed {
        logic load;
        logic scan;
        logic sig;
        logic clear;
    } mode_sel_t;

    // Set a stage index in the tap mask.
    function automatic logic [31:0] stage_bit(input int idx);
        logic [31:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    // Tap mask of a maximal-length polynomial. Bit k set means stage k feeds
    // the XOR that drives stage 0. A polynomial term x^e maps to stage e-1.
    function automatic logic [31:0] tap_mask(input int width);
        logic [31:0] m;
        case (width)
            2:  m = stage_bit(1)  | stage_bit(0);
            3:  m = stage_bit(2)  | stage_bit(1);
            4:  m = stage_bit(3)  | stage_bit(2);
            5:  m = stage_bit(4)  | stage_bit(2);
            6:  m = stage_bit(5)  | stage_bit(4);
            7:  m = stage_bit(6)  | stage_bit(5);
            8:  m = stage_bit(7)  | stage_bit(5)  | stage_bit(4)  | stage_bit(3);
            9:  m = stage_bit(8)  | stage_bit(4);
            10: m = stage_bit(9)  | stage_bit(6);
            11: m = stage_bit(10) | stage_bit(8);
            12: m = stage_bit(11) | stage_bit(10) | stage_bit(9)  | stage_bit(3);
            13: m = stage_bit(12) | stage_bit(11) | stage_bit(10) | stage_bit(7);
            14: m = stage_bit(13) | stage_bit(12) | stage_bit(11) | stage_bit(1);
            15: m = stage_bit(14) | stage_bit(13);
            16: m = stage_bit(15) | stage_bit(14) | stage_bit(12) | stage_bit(3);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/selftest_mode_decode.sv
// Module: turns the two-bit mode code into one-hot stage controls.
// Assumes mode_ctl is known whenever it is sampled. All four codes are legal.
module selftest_mode_decode
    import selftest_pkg::*;
(
    input  logic [1:0] mode_ctl,
    output mode_sel_t  sel
);

    // Decode the mode code into exactly one active control.
    always_comb begin
        sel = '0;
        case (mode_e'(mode_ctl))
            MODE_LOAD:  sel.load  = 1'b1;
            MODE_SCAN:  sel.scan  = 1'b1;
            MODE_SIG:   sel.sig   = 1'b1;
            MODE_CLEAR: sel.clear = 1'b1;
            default:    sel.clear = 1'b1;
        endcase
    end

endmodule

// File: rtl/selftest_feedback.sv
// Module: XOR of the tap stages that drive stage 0 in self-test mode.
// Assumes TAPS is a maximal-length mask for WIDTH (see selftest_pkg).
module selftest_feedback #(
    parameter int              WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS = '0
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);

    logic [WIDTH-1:0] gated;

    // Mask each stage by its tap bit.
    genvar k;
    generate
        for (k = 0; k < WIDTH; k++) begin : g_gate
            assign gated[k] = state[k] & TAPS[k];
        end
    endgenerate

    // Reduce the gated stages to one feedback bit.
    always_comb fb = ^gated;

endmodule

// File: rtl/selftest_cell.sv
// Module: one stage of the register, a flop with a four-way next-value mux.
// Assumes sel is one-hot. The stage supplies scan_src and sig_src from its
// neighbour, or from scan_in and the feedback bit when it is stage 0.
module selftest_cell
    import selftest_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mode_sel_t sel,
    input  logic      par_bit,
    input  logic      scan_src,
    input  logic      sig_src,
    output logic      q
);

    logic nxt;

    // Select the next value of this stage from the active mode.
    always_comb begin
        nxt = 1'b0;
        if (sel.load)      nxt = par_bit;
        else if (sel.scan) nxt = scan_src;
        else if (sel.sig)  nxt = par_bit ^ sig_src;
        else               nxt = 1'b0;
    end

    // Update the stage on the clock edge, with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

endmodule

// File: rtl/selftest_reg.sv
// Module: multifunction self-test register (top).
// Four modes are available: parallel capture, serial scan, signature or
// pattern generation, and synchronous clear. Stage WIDTH-1 drives scan_out.
// Assumes WIDTH is between 2 and 16 so that a maximal tap mask exists.
module selftest_reg
    import selftest_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_ctl,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);

    localparam logic [31:0]      FULL_MASK = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAP_MASK  = FULL_MASK[WIDTH-1:0];

    mode_sel_t        sel;
    logic             fb;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] scan_src;
    logic [WIDTH-1:0] sig_src;

    selftest_mode_decode u_decode (
        .mode_ctl (mode_ctl),
        .sel      (sel)
    );

    selftest_feedback #(
        .WIDTH (WIDTH),
        .TAPS  (TAP_MASK)
    ) u_feedback (
        .state (stage_q),
        .fb    (fb)
    );

    // Chain sources: stage 0 takes the external inputs, the others their neighbour.
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign scan_src[i] = scan_in;
                assign sig_src[i]  = fb;
            end else begin : g_body
                assign scan_src[i] = stage_q[i-1];
                assign sig_src[i]  = stage_q[i-1];
            end

            selftest_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel      (sel),
                .par_bit  (par_in[i]),
                .scan_src (scan_src[i]),
                .sig_src  (sig_src[i]),
                .q        (stage_q[i])
            );
        end
    endgenerate

    // Drive the outputs from the stage flops.
    assign par_out  = stage_q;
    assign scan_out = stage_q[WIDTH-1];

endmodule

// File: rtl/selftest_reg_chk.sv
// Module: assertion checker for selftest_reg, attached with bind.
// Assumes known inputs whenever rst_n is high.
module selftest_reg_chk
    import selftest_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_ctl,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] par_out,
    input logic             scan_out
);

    localparam logic [31:0]      FULL_MASK = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0] TAP_MASK  = FULL_MASK[WIDTH-1:0];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (par_out == '0)); // R1

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl == 2'b11) |=> (par_out == $past(par_in))); // R2

    AST_SCAN_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl == 2'b00) |=> (par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)})); // R3

    AST_SCAN_OUT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == par_out[WIDTH-1]); // R4

    AST_SIG_BODY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl == 2'b10) |=> (par_out[WIDTH-1:1] == ($past(par_in[WIDTH-1:1]) ^ $past(par_out[WIDTH-2:0])))); // R5

    AST_SIG_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl == 2'b10) |=> (par_out[0] == ($past(par_in[0]) ^ (^($past(par_out) & TAP_MASK))))); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ctl == 2'b01) |=> (par_out == '0)); // R6

    AST_GEN_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_ctl == 2'b10) && (par_in == '0) && (par_out != '0)) |=> (par_out != '0)); // R7

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_ctl == 2'b10) && (par_in == '0) && (par_out == '0)) |=> (par_out == '0)); // R8

endmodule

bind selftest_reg selftest_reg_chk #(.WIDTH(WIDTH)) u_selftest_reg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_ctl (mode_ctl),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/test_selftest_reg.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of the register, compared on every clock.
module test_selftest_reg;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_ctl = 2'b11;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_out;
    logic         scan_out;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 1'b0;
    int  mdl[W];               // reference stage values, index 0 = first stage
    bit  visited[int];         // states seen during the pattern run

    always #10 clk = ~clk;     // 50 MHz

    selftest_reg #(.WIDTH(W)) i_selftest_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ctl (mode_ctl),
        .par_in   (par_in),
        .scan_in  (scan_in),
        .par_out  (par_out),
        .scan_out (scan_out)
    );

    // Pack the model array into an integer, with stage i as bit i.
    function automatic int model_word();
        int v = 0;
        for (int i = 0; i < W; i++) v += mdl[i] << i;
        return v;
    endfunction

    // Advance the model by one edge, following the requirements.
    task automatic model_step(input bit r, input bit [1:0] m, input bit [W-1:0] pin, input bit sin);
        int old[W];
        for (int i = 0; i < W; i++) old[i] = mdl[i];
        for (int i = 0; i < W; i++) begin
            if (!r)             mdl[i] = 0;                       // R1
            else if (m == 2'b11) mdl[i] = pin[i];                 // R2
            else if (m == 2'b01) mdl[i] = 0;                      // R6
            else if (m == 2'b00) mdl[i] = (i == 0) ? sin : old[i-1]; // R3
            else                 mdl[i] = pin[i] ^ ((i == 0) ? (old[3] ^ old[2]) : old[i-1]); // R5
        end
    endtask

    // Drive one vector at a falling edge, then compare at the next falling edge.
    task automatic cycle(input bit r, input bit [1:0] m, input bit [W-1:0] pin, input bit sin, input string req);
        int exp_w;
        rst_n = r; mode_ctl = m; par_in = pin; scan_in = sin;
        @(posedge clk);
        model_step(r, m, pin, sin);
        @(negedge clk);
        exp_w = model_word();
        vectors++;
        if (par_out !== exp_w[W-1:0] || scan_out !== exp_w[W-1]) begin
            fails++;
            $display("FAIL %s: par_out=%b scan_out=%b expected par_out=%b scan_out=%b",
                     req, par_out, scan_out, exp_w[W-1:0], exp_w[W-1]);
        end
    endtask

    // Count one standalone check.
    task automatic check_int(input int act, input int exp, input string req);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Print the summary line and stop.
    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Main stimulus sequence.
    initial begin
        for (int i = 0; i < W; i++) mdl[i] = 0;
        @(negedge clk);
        cycle(0, 2'b11, 4'hF, 1, "R1 reset");
        cycle(0, 2'b10, 4'hA, 1, "R1 reset");

        cycle(1, 2'b11, 4'h5, 0, "R2 capture");
        cycle(1, 2'b11, 4'hA, 1, "R2 capture");
        cycle(1, 2'b11, 4'h0, 1, "R2 capture");
        cycle(1, 2'b11, 4'hF, 0, "R2 capture");
        for (int k = 0; k < 4; k++) cycle(1, 2'b11, 4'($urandom), 1'($urandom), "R2 capture");

        // Scan a pattern in and back out; scan_out is checked each cycle.
        cycle(1, 2'b00, 4'h3, 1, "R3 scan");
        cycle(1, 2'b00, 4'hC, 0, "R3 scan");
        cycle(1, 2'b00, 4'h0, 1, "R3 scan");
        cycle(1, 2'b00, 4'hF, 1, "R3 scan");
        for (int k = 0; k < 6; k++) cycle(1, 2'b00, 4'($urandom), 1'($urandom), "R4 scan_out");

        // Signature compaction with live inputs.
        cycle(1, 2'b11, 4'h9, 0, "R2 seed");
        for (int k = 0; k < 12; k++) cycle(1, 2'b10, 4'($urandom), 1'($urandom), "R5 self-test");

        // Clear ignores the data inputs.
        cycle(1, 2'b11, 4'hE, 0, "R2 seed");
        cycle(1, 2'b01, 4'hF, 1, "R6 clear");
        cycle(1, 2'b01, 4'h7, 1, "R6 clear");

        // Pattern run: full period from a single-bit seed.
        cycle(1, 2'b11, 4'h1, 0, "R2 seed");
        visited.delete();
        for (int k = 0; k < 15; k++) begin
            cycle(1, 2'b10, 4'h0, 0, "R7 pattern");
            visited[int'(par_out)] = 1'b1;
            vectors++;
            if (par_out == '0) begin
                fails++;
                $display("FAIL R7: par_out=%b expected nonzero", par_out);
            end
        end
        check_int(visited.num(), 15, "R7 distinct states");
        check_int(int'(par_out), 1, "R7 return to seed");

        // Lock-up corner: an all-zero register stays zero.
        cycle(1, 2'b01, 4'h0, 0, "R6 clear");
        for (int k = 0; k < 5; k++) cycle(1, 2'b10, 4'h0, 1, "R8 zero state");

        // Reset in the middle of activity.
        cycle(1, 2'b11, 4'hB, 0, "R2 capture");
        cycle(0, 2'b00, 4'hF, 1, "R1 reset");
        cycle(1, 2'b10, 4'h0, 0, "R8 zero state");

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule